// File: doc/BRIEF.md
# Keyed Page and Bank Control Registers

This block holds the memory-mapping controls of a cartridge that carries several memories behind one bus. It watches 16-bit writes carrying byte addresses. A control register changes only inside a framed sequence of six writes: a fixed four-write key, a single payload write whose address selects the register, and a closing write. The payload is parked in a pending register. It reaches the selected register only when the closing write arrives, so a partial or garbled frame leaves every output as it was.

Four registers are committed this way. The ROM page register carries the mode, the NOR bank and the page number. The RAM page register is a plain 16-bit value. There is a write-enable flag and a two-bit NAND interface control. The outputs give the decoded ROM byte offset, the effective NOR bank, the OS/game mode, the RAM page, the write-enable state and the NAND enable and width. The memories and the NAND port itself sit outside the block.

Top module: `keyed_bank_regs`

## Requirements
- R1: Reset (rst_n low at a clock edge) gives os_mode=1, rom_offset=0, nor_bank=0, ram_page=0, wr_open=0, nand_en=0 and nand_wide=0.
- R2: A complete frame aimed at the ROM page register (address 0x09880000) updates the outputs on the clock edge that takes the closing write. os_mode becomes data bit 15, and rom_offset becomes data bits 8..0 multiplied by 2^17 (1 Mbit pages, in bytes).
- R3: nor_bank shows data bits 13..12 of the committed ROM page value while os_mode=1, and is 0 while os_mode=0, whatever those bits hold.
- R4: A complete frame aimed at the RAM page register (address 0x09C00000) copies the 16-bit payload to ram_page.
- R5: A complete frame aimed at the write-enable control (address 0x09C40000) sets wr_open with payload 0x1500, clears it with 0xD200, and leaves it unchanged for any other payload.
- R6: A complete frame aimed at the NAND control (address 0x09400000) sets nand_en from payload bit 0 and nand_wide from payload bit 1.
- R7: No output changes between the payload write and the closing write, and idle cycles without a write may sit between any two writes of a frame.
- R8: A write that does not match the expected key step abandons the frame. The payload and closing writes that follow then change nothing.
- R9: A write in the closing slot that is not 0x1500 to 0x09FC0000 discards the pending payload, and a later closing write does not commit it.
- R10: A payload address that matches none of the four registers lets the frame complete with no output change.
- R11: A frame is the key 0xD200@0x09FE0000, 0x1500@0x08000000, 0xD200@0x08020000, 0x1500@0x08040000, then the payload, then 0x1500@0x09FC0000. A write equal to the first key step that breaks a frame starts a new key at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_addr | input | 32 | Byte address of the write |
| bus_wdata | input | 16 | Write data |
| rom_offset | output | 26 | ROM window byte offset from the page number |
| nor_bank | output | 2 | Effective NOR bank (0 in game mode) |
| os_mode | output | 1 | 1 = OS mode, 0 = game mode |
| ram_page | output | 16 | Committed RAM page |
| wr_open | output | 1 | Writes to the RAM are allowed |
| nand_en | output | 1 | NAND interface enabled |
| nand_wide | output | 1 | NAND data width is 16 bits (0 = 8 bits) |

## Verification
The bench goes after the frame corners. It holds back the closing write across idle cycles, where a design that commits at the payload would change the outputs too early. It corrupts one key step, which a design without a sequence check would let through to change ram_page. It sends a wrong closing write followed by a correct one, and a design that keeps the pending payload would commit it late. It also sends an unmapped payload and an unrecognised write-enable code, where a loose decoder would clobber some register, and it enters game mode with nonzero bank bits, where a design that does not mask them would show a nonzero nor_bank.

// File: rtl/keyed_regs_pkg.sv
// Package: shared types and fixed bus constants of the keyed register block.
// Assumes byte addresses up to 32 bits and 16-bit write data.
package keyed_regs_pkg;

    // Register chosen by a payload address
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_RAM  = 3'd2,
        TGT_WEN  = 3'd3,
        TGT_NAND = 3'd4
    } tgt_e;

    // Frame phase of the sequencer
    typedef enum logic [1:0] {
        PH_KEY = 2'd0,
        PH_PAY = 2'd1,
        PH_CLS = 2'd2
    } phase_e;

    localparam int KEY_LEN = 4;

    localparam logic [31:0] KEY_ADDR [KEY_LEN] = '{
        32'h09FE_0000, 32'h0800_0000, 32'h0802_0000, 32'h0804_0000
    };
    localparam logic [15:0] KEY_DATA [KEY_LEN] = '{
        16'hD200, 16'h1500, 16'hD200, 16'h1500
    };

    localparam logic [31:0] CLOSE_ADDR = 32'h09FC_0000;
    localparam logic [15:0] CLOSE_DATA = 16'h1500;

    localparam logic [31:0] ROM_ADDR  = 32'h0988_0000;
    localparam logic [31:0] RAM_ADDR  = 32'h09C0_0000;
    localparam logic [31:0] WEN_ADDR  = 32'h09C4_0000;
    localparam logic [31:0] NAND_ADDR = 32'h0940_0000;

    localparam logic [15:0] WEN_OPEN = 16'h1500;
    localparam logic [15:0] WEN_SHUT = 16'hD200;

    // ROM page register field positions (consumed by the output map)
    localparam int ROM_OS_BIT  = 15;
    localparam int ROM_BANK_LO = 12;

    // Reset value of the ROM page register: OS mode, bank 0, page 0
    localparam logic [15:0] ROM_RESET = 16'h8000;

endpackage

// File: rtl/keyed_addr_dec.sv
// Module: maps a payload address to the register it selects.
// Assumes exact address match; anything else decodes to TGT_NONE.
module keyed_addr_dec
    import keyed_regs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o
);

    // Compare the address against each register location
    always_comb begin
        tgt_o = TGT_NONE;
        if (addr_i == ROM_ADDR[ADDR_W-1:0])       tgt_o = TGT_ROM;
        else if (addr_i == RAM_ADDR[ADDR_W-1:0])  tgt_o = TGT_RAM;
        else if (addr_i == WEN_ADDR[ADDR_W-1:0])  tgt_o = TGT_WEN;
        else if (addr_i == NAND_ADDR[ADDR_W-1:0]) tgt_o = TGT_NAND;
    end

endmodule

// File: rtl/keyed_seq.sv
// Module: frame sequencer. Checks the key writes in order, parks the payload
// and its decoded target, and raises commit for one cycle on a valid close.
// Assumes at most one write per cycle; cycles without bus_wr hold the state.
module keyed_seq
    import keyed_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  tgt_e              dec_tgt_i,
    output logic              commit_o,
    output tgt_e              commit_tgt_o,
    output logic [DATA_W-1:0] commit_data_o
);

    localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(KEY_LEN - 1);

    logic [KEY_LEN-1:0] key_hit;
    logic               close_hit;
    phase_e             ph_q, ph_d;
    logic [CNT_W-1:0]   step_q, step_d;
    tgt_e               pend_tgt_q;
    logic [DATA_W-1:0]  pend_data_q;

    // One matcher per key step
    for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
        assign key_hit[k] = wr_i
                          && (addr_i == KEY_ADDR[k][ADDR_W-1:0])
                          && (data_i == KEY_DATA[k][DATA_W-1:0]);
    end

    assign close_hit = wr_i
                     && (addr_i == CLOSE_ADDR[ADDR_W-1:0])
                     && (data_i == CLOSE_DATA[DATA_W-1:0]);

    // Next phase, key step and commit strobe
    always_comb begin
        ph_d     = ph_q;
        step_d   = step_q;
        commit_o = 1'b0;
        if (wr_i) begin
            unique case (ph_q)
                PH_KEY: begin
                    if (key_hit[step_q]) begin
                        if (step_q == LAST_STEP) begin
                            ph_d   = PH_PAY;
                            step_d = '0;
                        end else begin
                            step_d = step_q + 1'b1;
                        end
                    end else begin
                        step_d = key_hit[0] ? CNT_W'(1) : '0;
                    end
                end
                PH_PAY: begin
                    ph_d = PH_CLS;
                end
                PH_CLS: begin
                    ph_d = PH_KEY;
                    if (close_hit) begin
                        commit_o = 1'b1;
                        step_d   = '0;
                    end else begin
                        step_d = key_hit[0] ? CNT_W'(1) : '0;
                    end
                end
                default: begin
                    ph_d   = PH_KEY;
                    step_d = '0;
                end
            endcase
        end
    end

    // Frame state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_KEY;
            step_q <= '0;
        end else begin
            ph_q   <= ph_d;
            step_q <= step_d;
        end
    end

    // Pending payload capture in the payload slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tgt_q  <= TGT_NONE;
            pend_data_q <= '0;
        end else if (wr_i && ph_q == PH_PAY) begin
            pend_tgt_q  <= dec_tgt_i;
            pend_data_q <= data_i;
        end
    end

    assign commit_tgt_o  = pend_tgt_q;
    assign commit_data_o = pend_data_q;

endmodule

// File: rtl/keyed_reg_file.sv
// Module: the committed control registers, written only on a commit strobe.
// Assumes commit data carries the full payload word of the frame.
module keyed_reg_file
    import keyed_regs_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int RAM_PAGE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_i,
    input  tgt_e                  tgt_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic [DATA_W-1:0]     rom_q,
    output logic [RAM_PAGE_W-1:0] ram_q,
    output logic                  wen_q,
    output logic [1:0]            nand_q
);

    // ROM page/mode register
    always_ff @(posedge clk) begin
        if (!rst_n)                            rom_q <= ROM_RESET[DATA_W-1:0];
        else if (commit_i && tgt_i == TGT_ROM) rom_q <= data_i;
    end

    // RAM page register
    always_ff @(posedge clk) begin
        if (!rst_n)                            ram_q <= '0;
        else if (commit_i && tgt_i == TGT_RAM) ram_q <= data_i[RAM_PAGE_W-1:0];
    end

    // Write-enable flag: two recognised codes, others leave it alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
        end else if (commit_i && tgt_i == TGT_WEN) begin
            if (data_i == WEN_OPEN[DATA_W-1:0])      wen_q <= 1'b1;
            else if (data_i == WEN_SHUT[DATA_W-1:0]) wen_q <= 1'b0;
        end
    end

    // NAND control: bit 1 width, bit 0 enable
    always_ff @(posedge clk) begin
        if (!rst_n)                             nand_q <= 2'b00;
        else if (commit_i && tgt_i == TGT_NAND) nand_q <= data_i[1:0];
    end

endmodule

// File: rtl/keyed_out_map.sv
// Module: turns the committed register words into mapping outputs.
// Assumes the ROM page register layout given by the package positions.
module keyed_out_map
    import keyed_regs_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ROM_PAGE_W = 9,
    parameter int PAGE_SHIFT = 17,
    parameter int BANK_W     = 2
) (
    input  logic [DATA_W-1:0]                rom_i,
    input  logic [1:0]                       nand_i,
    output logic [ROM_PAGE_W+PAGE_SHIFT-1:0] rom_offset_o,
    output logic [BANK_W-1:0]                nor_bank_o,
    output logic                             os_mode_o,
    output logic                             nand_en_o,
    output logic                             nand_wide_o
);

    logic unused_rom_bits;

    // Mode, masked bank and page-to-offset conversion
    always_comb begin
        os_mode_o    = rom_i[ROM_OS_BIT];
        nor_bank_o   = os_mode_o ? rom_i[ROM_BANK_LO +: BANK_W] : '0;
        rom_offset_o = {rom_i[ROM_PAGE_W-1:0], {PAGE_SHIFT{1'b0}}};
        nand_en_o    = nand_i[0];
        nand_wide_o  = nand_i[1];
    end

    assign unused_rom_bits = ^{rom_i[DATA_W-2:ROM_BANK_LO+BANK_W],
                               rom_i[ROM_BANK_LO-1:ROM_PAGE_W]};

endmodule

// File: rtl/keyed_bank_regs.sv
// Module: top of the keyed page and bank control block. Every register
// update needs a key, one address-selected payload and a closing write.
// Assumes one 16-bit write per cycle at most, byte addressed.
module keyed_bank_regs
    import keyed_regs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 16,
    parameter int ROM_PAGE_W = 9,
    parameter int PAGE_SHIFT = 17,
    parameter int BANK_W     = 2,
    parameter int RAM_PAGE_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [ROM_PAGE_W+PAGE_SHIFT-1:0] rom_offset,
    output logic [BANK_W-1:0]                nor_bank,
    output logic                             os_mode,
    output logic [RAM_PAGE_W-1:0]            ram_page,
    output logic                             wr_open,
    output logic                             nand_en,
    output logic                             nand_wide
);

    tgt_e              dec_tgt;
    logic              seq_commit;
    tgt_e              seq_tgt;
    logic [DATA_W-1:0] seq_data;
    logic [DATA_W-1:0] rom_word;
    logic [1:0]        nand_word;

    keyed_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .tgt_o  (dec_tgt)
    );

    keyed_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (bus_wr),
        .addr_i        (bus_addr),
        .data_i        (bus_wdata),
        .dec_tgt_i     (dec_tgt),
        .commit_o      (seq_commit),
        .commit_tgt_o  (seq_tgt),
        .commit_data_o (seq_data)
    );

    keyed_reg_file #(.DATA_W(DATA_W), .RAM_PAGE_W(RAM_PAGE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (seq_commit),
        .tgt_i    (seq_tgt),
        .data_i   (seq_data),
        .rom_q    (rom_word),
        .ram_q    (ram_page),
        .wen_q    (wr_open),
        .nand_q   (nand_word)
    );

    keyed_out_map #(
        .DATA_W(DATA_W), .ROM_PAGE_W(ROM_PAGE_W),
        .PAGE_SHIFT(PAGE_SHIFT), .BANK_W(BANK_W)
    ) u_map (
        .rom_i        (rom_word),
        .nand_i       (nand_word),
        .rom_offset_o (rom_offset),
        .nor_bank_o   (nor_bank),
        .os_mode_o    (os_mode),
        .nand_en_o    (nand_en),
        .nand_wide_o  (nand_wide)
    );

endmodule

// File: rtl/keyed_bank_regs_chk.sv
// Module: property checker for keyed_bank_regs, attached by bind below.
// Assumes it sees the commit strobe and target from the sequencer.
module keyed_bank_regs_chk
    import keyed_regs_pkg::*;
#(
    parameter int OFF_W      = 26,
    parameter int PAGE_SHIFT = 17,
    parameter int BANK_W     = 2,
    parameter int RAM_PAGE_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  commit,
    input tgt_e                  commit_tgt,
    input logic [OFF_W-1:0]      rom_offset,
    input logic [BANK_W-1:0]     nor_bank,
    input logic                  os_mode,
    input logic [RAM_PAGE_W-1:0] ram_page,
    input logic                  wr_open,
    input logic                  nand_en,
    input logic                  nand_wide
);

    // R7: outputs only move on the edge after a commit
    p_hold_without_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({rom_offset, nor_bank, os_mode, ram_page,
                             wr_open, nand_en, nand_wide}));

    // R3: game mode never exposes a bank
    p_game_bank_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !os_mode |-> nor_bank == '0);

    // R2: offset is whole pages
    p_offset_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_offset[PAGE_SHIFT-1:0] == '0);

    // R4: RAM page moves only from a RAM-targeted commit
    p_ram_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_page) |-> $past(commit && commit_tgt == TGT_RAM));

    // R5: write enable moves only from a write-enable commit
    p_wen_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_open) |-> $past(commit && commit_tgt == TGT_WEN));

    // R6: NAND control moves only from a NAND commit
    p_nand_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({nand_en, nand_wide}) |-> $past(commit && commit_tgt == TGT_NAND));

endmodule

bind keyed_bank_regs keyed_bank_regs_chk #(
    .OFF_W(ROM_PAGE_W + PAGE_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
    .BANK_W(BANK_W), .RAM_PAGE_W(RAM_PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (seq_commit),
    .commit_tgt (seq_tgt),
    .rom_offset (rom_offset),
    .nor_bank   (nor_bank),
    .os_mode    (os_mode),
    .ram_page   (ram_page),
    .wr_open    (wr_open),
    .nand_en    (nand_en),
    .nand_wide  (nand_wide)
);

// File: tb/tb_keyed_bank_regs.sv
module tb_keyed_bank_regs;

    localparam int OFF_W = 26;
    localparam int VW    = 79;
    localparam int NVEC  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [31:0]      bus_addr = '0;
    logic [15:0]      bus_wdata = '0;
    logic [OFF_W-1:0] rom_offset;
    logic [1:0]       nor_bank;
    logic             os_mode;
    logic [15:0]      ram_page;
    logic             wr_open, nand_en, nand_wide;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keyed_bank_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rom_offset(rom_offset), .nor_bank(nor_bank),
        .os_mode(os_mode), .ram_page(ram_page), .wr_open(wr_open),
        .nand_en(nand_en), .nand_wide(nand_wide)
    );

    // {payload addr, payload data, os, bank, page, ram, we, nand_en, nand_wide}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {32'h0988_0000, 16'hB005, 1'b1, 2'd3, 9'h005, 16'h0000, 1'b0, 1'b0, 1'b0},
        {32'h09C0_0000, 16'h1234, 1'b1, 2'd3, 9'h005, 16'h1234, 1'b0, 1'b0, 1'b0},
        {32'h09C4_0000, 16'h1500, 1'b1, 2'd3, 9'h005, 16'h1234, 1'b1, 1'b0, 1'b0},
        {32'h0940_0000, 16'h0003, 1'b1, 2'd3, 9'h005, 16'h1234, 1'b1, 1'b1, 1'b1},
        {32'h0988_0000, 16'h21FF, 1'b0, 2'd0, 9'h1FF, 16'h1234, 1'b1, 1'b1, 1'b1},
        {32'h09C4_0000, 16'h1234, 1'b0, 2'd0, 9'h1FF, 16'h1234, 1'b1, 1'b1, 1'b1},
        {32'h0940_0000, 16'h0001, 1'b0, 2'd0, 9'h1FF, 16'h1234, 1'b1, 1'b1, 1'b0},
        {32'h0900_0000, 16'hFFFF, 1'b0, 2'd0, 9'h1FF, 16'h1234, 1'b1, 1'b1, 1'b0},
        {32'h09C4_0000, 16'hD200, 1'b0, 2'd0, 9'h1FF, 16'h1234, 1'b0, 1'b1, 1'b0},
        {32'h0988_0000, 16'h9100, 1'b1, 2'd1, 9'h100, 16'h1234, 1'b0, 1'b1, 1'b0},
        {32'h09C0_0000, 16'hFFFF, 1'b1, 2'd1, 9'h100, 16'hFFFF, 1'b0, 1'b1, 1'b0},
        {32'h0940_0000, 16'h0002, 1'b1, 2'd1, 9'h100, 16'hFFFF, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All outputs against one expected state; tags by field
    task automatic check_all(input logic e_os, input logic [1:0] e_bank,
                             input logic [8:0] e_page, input logic [15:0] e_ram,
                             input logic e_we, input logic e_ne, input logic e_nw,
                             input string ctx);
        check({ctx, " R2"}, "os_mode", 32'(os_mode), 32'(e_os));
        check({ctx, " R2"}, "rom_offset", 32'(rom_offset), 32'({e_page, 17'b0}));
        check({ctx, " R3"}, "nor_bank", 32'(nor_bank), 32'(e_bank));
        check({ctx, " R4"}, "ram_page", 32'(ram_page), 32'(e_ram));
        check({ctx, " R5"}, "wr_open", 32'(wr_open), 32'(e_we));
        check({ctx, " R6"}, "nand_en", 32'(nand_en), 32'(e_ne));
        check({ctx, " R6"}, "nand_wide", 32'(nand_wide), 32'(e_nw));
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic send_key();
        wr(32'h09FE_0000, 16'hD200);
        wr(32'h0800_0000, 16'h1500);
        wr(32'h0802_0000, 16'hD200);
        wr(32'h0804_0000, 16'h1500);
    endtask

    task automatic frame(input logic [31:0] a, input logic [15:0] d);
        send_key();
        wr(a, d);
        wr(32'h09FC_0000, 16'h1500);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all(1'b1, 2'd0, 9'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R1 reset");

        // Table walk: R2..R6, row 5 game-mode mask R3, row 8 unmapped R10
        for (int i = 0; i < NVEC; i++) begin
            frame(VEC[i][78:47], VEC[i][46:31]);
            check_all(VEC[i][30], VEC[i][29:28], VEC[i][27:19], VEC[i][18:3],
                      VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));
        end

        // R7: payload parked, idle cycles, nothing moves until close
        send_key();
        repeat (3) @(negedge clk);
        wr(32'h0988_0000, 16'h0000);
        repeat (4) @(negedge clk);
        check("R7", "os_mode before close", 32'(os_mode), 32'd1);
        check("R7", "rom_offset before close", 32'(rom_offset), 32'(9'h100) << 17);
        wr(32'h09FC_0000, 16'h1500);
        check("R7", "os_mode after close", 32'(os_mode), 32'd0);
        check("R7", "rom_offset after close", 32'(rom_offset), 32'd0);

        // R8: broken second key step, rest of frame ignored
        wr(32'h09FE_0000, 16'hD200);
        wr(32'h0800_0000, 16'hD200);
        wr(32'h0802_0000, 16'hD200);
        wr(32'h0804_0000, 16'h1500);
        wr(32'h09C0_0000, 16'h0F0F);
        wr(32'h09FC_0000, 16'h1500);
        check("R8", "ram_page after bad key", 32'(ram_page), 32'hFFFF);

        // R9: wrong close then a good one; payload must be gone
        send_key();
        wr(32'h09C0_0000, 16'h0A0A);
        wr(32'h09FC_0000, 16'hD200);
        wr(32'h09FC_0000, 16'h1500);
        check("R9", "ram_page after bad close", 32'(ram_page), 32'hFFFF);

        // R10: unmapped payload near a real address
        frame(32'h0988_0002, 16'h8FFF);
        check("R10", "os_mode unmapped", 32'(os_mode), 32'd0);
        check("R10", "rom_offset unmapped", 32'(rom_offset), 32'd0);
        check("R10", "ram_page unmapped", 32'(ram_page), 32'hFFFF);
        check("R10", "nand unmapped", 32'({nand_wide, nand_en}), 32'd2);

        // R11: repeated first key step restarts the key
        wr(32'h09FE_0000, 16'hD200);
        send_key();
        wr(32'h0940_0000, 16'h0001);
        wr(32'h09FC_0000, 16'h1500);
        check("R11", "nand_en after restart", 32'(nand_en), 32'd1);
        check("R11", "nand_wide after restart", 32'(nand_wide), 32'd0);

        // R11: a bad close that equals key step 0 starts a new key
        send_key();
        wr(32'h09C0_0000, 16'h5555);
        wr(32'h09FE_0000, 16'hD200);
        wr(32'h0800_0000, 16'h1500);
        wr(32'h0802_0000, 16'hD200);
        wr(32'h0804_0000, 16'h1500);
        wr(32'h09C0_0000, 16'h00AA);
        wr(32'h09FC_0000, 16'h1500);
        check("R11", "ram_page restart in close slot", 32'(ram_page), 32'h00AA);

        // R1: reset again from a modified state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all(1'b1, 2'd0, 9'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R1 re-reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule